// File: doc/BRIEF.md
# Shared-PLL Divider Mapper for Four Clock Regions

This block turns four requested clock frequencies, one for each reconfigurable region of a device, into the register writes that program one shared PLL. Each region asks for a 3-bit frequency code. On a start strobe the block does four things in order:

- It sorts the four codes and remembers which output each sorted code came from.
- It classifies the sorted set by how its values repeat.
- It looks up the divider words for that set in a small ROM built inside the block.
- It sends the words to the PLL register file, one write per cycle. Each per-output divider goes back to the register of the output that asked for it.

The table is indexed by the set of distinct frequencies and not by the raw four-code combination. Every permutation of the same request therefore shares one entry. This brings the storage from 1296 combinations down to 71 entries in five groups. The groups are:

| Group | Pattern | Entries | Words per entry |
|---|---|---|---|
| 1 | all four codes distinct | 15 | 5 |
| 2 | exactly one pair | 20 | 4 |
| 3 | two pairs | 15 | 3 |
| 4 | three alike | 15 | 3 |
| 5 | all four equal | 6 | 2 |

In each entry, word 0 is the common divider. The words after it are the dividers for each distinct frequency, in ascending order.

A controller pulses start with the four codes valid. It then consumes the write stream. It waits for the done pulse before it issues the next request.

Top module: `clkmap_top`

## Requirements
- R1: While reset is high and in the first cycle after it, wr_valid, done and err are all 0.
- R2: Code c in 0..5 stands for (c+1)*30 MHz. The first write of a sequence goes to register address 0. Its data is L, the least common multiple of (c+1) over the four requested codes.
- R3: Output o (0..3) receives one write at register address 2+3*o, so addresses 2, 5, 8 and 11. Its data is L/(c_o+1), where c_o is the code that output o requested.
- R4: A start accepted at clock edge T produces writes on the five cycles that follow. The addresses come in the order 0, 2, 5, 8, 11, with wr_valid high on each of these cycles and on no other.
- R5: done is high for exactly one cycle, the cycle right after the write to address 11. wr_valid is low in that cycle.
- R6: A start that arrives while a sequence is running is ignored. A change on the request codes at that time is also ignored: the running sequence's addresses and data stay the same, and no extra sequence follows.
- R7: Results are correct for every repetition pattern of the request. The patterns are all distinct, one pair, two pairs, three alike and all equal. Results are also correct for any order of the same codes across the outputs.
- R8: If any code is 6 or 7 when start is accepted, err is high for one cycle, the cycle after that start. No write and no done follow.
- R9: The sorting network puts the codes in non-decreasing order. Equal codes keep ascending output index (the sort is stable).
- R10: For valid codes, the entry index computed inside a repetition group is always smaller than the number of entries in that group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe, sampled while idle |
| req_code0 | input | 3 | Frequency code requested by output 0 |
| req_code1 | input | 3 | Frequency code requested by output 1 |
| req_code2 | input | 3 | Frequency code requested by output 2 |
| req_code3 | input | 3 | Frequency code requested by output 3 |
| wr_valid | output | 1 | Register write strobe |
| wr_addr | output | 4 | PLL register address |
| wr_data | output | 32 | PLL register data |
| done | output | 1 | One-cycle pulse after the last write |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
The bench builds the block with its default parameters: four outputs, six legal frequencies and 32-bit data. With these values all five repetition groups and all 71 table entries can be reached through the ports, as can both illegal code values.

Directed requests cover:
- each repetition pattern;
- the worked permutation example;
- the largest common multiple (the set 4, 5, 6);
- a start and code change injected mid-sequence.

A fixed-seed random mix then exercises arbitrary permutations. The bench compares each result with least-common-multiple arithmetic computed directly from the codes.

// File: rtl/clkmap_pkg.sv
package clkmap_pkg;

    localparam int NUM_OUT    = 4;
    localparam int CODE_W     = 3;
    localparam int NUM_FREQ   = 6;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 4;
    localparam int IDX_W      = $clog2(NUM_OUT);
    localparam int STEP_W     = $clog2(NUM_OUT + 1);
    localparam int NUM_CAT    = 5;
    localparam int REG_COMMON = 0;
    localparam int REG_FIRST  = 2;
    localparam int REG_STRIDE = 3;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // Packed so that a plain magnitude compare orders by code, then by index.
    typedef struct packed {
        code_t code;
        idx_t  idx;
    } key_t;

    typedef key_t [NUM_OUT-1:0] key_vec_t;
    typedef idx_t [NUM_OUT-1:0] slot_vec_t;

    typedef enum logic [2:0] {
        CAT_DISTINCT = 3'd0,
        CAT_PAIR     = 3'd1,
        CAT_TWO_PAIR = 3'd2,
        CAT_TRIPLE   = 3'd3,
        CAT_SAME     = 3'd4
    } cat_e;

    function automatic int binom(int n, int r);
        int res;
        res = 1;
        if (r < 0 || r > n) return 0;
        for (int i = 0; i < r; i++) res = res * (n - i) / (i + 1);
        return res;
    endfunction

    function automatic int gcd_i(int a, int b);
        int x;
        int y;
        int t;
        x = a;
        y = b;
        for (int i = 0; i < 16; i++) begin
            if (y != 0) begin
                t = x % y;
                x = y;
                y = t;
            end
        end
        return x;
    endfunction

    function automatic int lcm_i(int a, int b);
        return (a / gcd_i(a, b)) * b;
    endfunction

    function automatic int cat_distinct(int c);
        case (c)
            0:       return 4;
            1:       return 3;
            2:       return 2;
            3:       return 2;
            default: return 1;
        endcase
    endfunction

    function automatic int cat_words(int c);
        return cat_distinct(c) + 1;
    endfunction

    function automatic int cat_entries(int c);
        return binom(NUM_FREQ, cat_distinct(c));
    endfunction

    function automatic int cat_base(int c);
        int b;
        b = 0;
        for (int i = 0; i < NUM_CAT; i++)
            if (i < c) b += cat_entries(i) * cat_words(i);
        return b;
    endfunction

    localparam int ROM_WORDS = cat_base(NUM_CAT);
    localparam int ROM_AW    = $clog2(ROM_WORDS);

    // Contents of one ROM word, derived from its address at elaboration.
    function automatic logic [DATA_W-1:0] rom_word(int a);
        int csel;
        int k;
        int off;
        int ent;
        int w;
        int cnt;
        int rnk;
        int l;
        int v [NUM_OUT];
        logic [DATA_W-1:0] res;
        res  = '0;
        csel = 0;
        for (int i = 0; i < NUM_OUT; i++) v[i] = 0;
        for (int c = 0; c < NUM_CAT; c++)
            if (a >= cat_base(c)) csel = c;
        k   = cat_distinct(csel);
        off = a - cat_base(csel);
        ent = off / cat_words(csel);
        w   = off % cat_words(csel);
        for (int m = 0; m < (1 << NUM_FREQ); m++) begin
            cnt = 0;
            rnk = 0;
            l   = 1;
            for (int f = 0; f < NUM_FREQ; f++) begin
                if (((m >> f) & 1) != 0) begin
                    if (cnt < NUM_OUT) v[cnt] = f;
                    rnk += binom(f, cnt + 1);
                    l = lcm_i(l, f + 1);
                    cnt++;
                end
            end
            if (cnt == k && rnk == ent) begin
                if (w == 0) res = DATA_W'(l);
                else        res = DATA_W'(l / (v[w-1] + 1));
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/clkmap_sorter.sv
module clkmap_sorter
    import clkmap_pkg::*;
(
    input  key_vec_t keys_in,
    output key_vec_t keys_out
);

    localparam int NUM_CMP = 5;
    localparam int PA [NUM_CMP] = '{0, 2, 0, 1, 1};
    localparam int PB [NUM_CMP] = '{1, 3, 2, 3, 2};

    key_t stage [NUM_CMP+1][NUM_OUT];

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_in
        assign stage[0][i] = keys_in[i];
    end

    for (genvar s = 0; s < NUM_CMP; s++) begin : g_cmp
        logic swap;
        assign swap = stage[s][PA[s]] > stage[s][PB[s]];
        for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
            if (i == PA[s]) begin : g_lo
                assign stage[s+1][i] = swap ? stage[s][PB[s]] : stage[s][PA[s]];
            end else if (i == PB[s]) begin : g_hi
                assign stage[s+1][i] = swap ? stage[s][PA[s]] : stage[s][PB[s]];
            end else begin : g_pass
                assign stage[s+1][i] = stage[s][i];
            end
        end
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        assign keys_out[i] = stage[NUM_CMP][i];
    end

endmodule

// File: rtl/clkmap_classifier.sv
module clkmap_classifier
    import clkmap_pkg::*;
(
    input  key_vec_t              sorted_keys,
    output cat_e                  cat,
    output slot_vec_t             slots,
    output logic [ROM_AW-1:0]     rank,
    output logic [ROM_AW-1:0]     entry_base,
    output logic                  codes_ok
);

    logic [NUM_OUT-2:0] eq;
    code_t              dv [NUM_OUT];
    int                 nd;
    int                 rk;

    always_comb begin
        for (int p = 0; p < NUM_OUT - 1; p++)
            eq[p] = sorted_keys[p].code == sorted_keys[p+1].code;

        for (int j = 0; j < NUM_OUT; j++) dv[j] = '0;
        slots[0] = '0;
        dv[0]    = sorted_keys[0].code;
        for (int p = 1; p < NUM_OUT; p++) begin
            slots[p]     = eq[p-1] ? slots[p-1] : slots[p-1] + idx_t'(1);
            dv[slots[p]] = sorted_keys[p].code;
        end
        nd = int'(slots[NUM_OUT-1]) + 1;

        rk = 0;
        for (int j = 0; j < NUM_OUT; j++)
            if (j < nd) rk += binom(int'(dv[j]), j + 1);

        case (eq)
            3'b000:                 cat = CAT_DISTINCT;
            3'b001, 3'b010, 3'b100: cat = CAT_PAIR;
            3'b101:                 cat = CAT_TWO_PAIR;
            3'b011, 3'b110:         cat = CAT_TRIPLE;
            default:                cat = CAT_SAME;
        endcase

        rank       = ROM_AW'(rk);
        entry_base = ROM_AW'(cat_base(int'(cat)) + rk * cat_words(int'(cat)));
        codes_ok   = int'(sorted_keys[NUM_OUT-1].code) < NUM_FREQ;
    end

endmodule

// File: rtl/clkmap_rom.sv
module clkmap_rom
    import clkmap_pkg::*;
(
    input  logic [ROM_AW-1:0] addr,
    output logic [DATA_W-1:0] data
);

    logic [DATA_W-1:0] words [ROM_WORDS];

    for (genvar a = 0; a < ROM_WORDS; a++) begin : g_word
        localparam logic [DATA_W-1:0] VAL = rom_word(a);
        assign words[a] = VAL;
    end

    assign data = (int'(addr) < ROM_WORDS) ? words[addr] : '0;

endmodule

// File: rtl/clkmap_writer.sv
module clkmap_writer
    import clkmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              codes_ok,
    input  key_vec_t          sorted_keys,
    input  slot_vec_t         slots,
    input  logic [ROM_AW-1:0] entry_base,
    input  logic [DATA_W-1:0] rom_data,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done,
    output logic              err
);

    logic              busy_q;
    logic [STEP_W-1:0] step_q;
    logic [ROM_AW-1:0] base_q;
    slot_vec_t         out_slot_q;
    idx_t              cur_slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= 1'b0;
            step_q     <= '0;
            base_q     <= '0;
            out_slot_q <= '0;
            done       <= 1'b0;
            err        <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    if (codes_ok) begin
                        busy_q <= 1'b1;
                        step_q <= '0;
                        base_q <= entry_base;
                        for (int p = 0; p < NUM_OUT; p++)
                            out_slot_q[sorted_keys[p].idx] <= slots[p];
                    end else begin
                        err <= 1'b1;
                    end
                end
            end else if (int'(step_q) == NUM_OUT) begin
                busy_q <= 1'b0;
                step_q <= '0;
                done   <= 1'b1;
            end else begin
                step_q <= step_q + STEP_W'(1);
            end
        end
    end

    always_comb begin
        cur_slot = '0;
        rom_addr = base_q;
        wr_addr  = ADDR_W'(REG_COMMON);
        if (step_q != '0) begin
            cur_slot = out_slot_q[IDX_W'(step_q - STEP_W'(1))];
            rom_addr = base_q + ROM_AW'(1) + ROM_AW'(cur_slot);
            wr_addr  = ADDR_W'(REG_FIRST + REG_STRIDE * (int'(step_q) - 1));
        end
        wr_valid = busy_q;
        wr_data  = rom_data;
    end

endmodule

// File: rtl/clkmap_top.sv
module clkmap_top
    import clkmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        req_code0,
    input  logic [2:0]        req_code1,
    input  logic [2:0]        req_code2,
    input  logic [2:0]        req_code3,
    output logic              wr_valid,
    output logic [3:0]        wr_addr,
    output logic [31:0]       wr_data,
    output logic              done,
    output logic              err
);

    code_t             req_arr [NUM_OUT];
    key_vec_t          raw_keys;
    key_vec_t          sorted_keys;
    cat_e              cls_cat;
    slot_vec_t         cls_slots;
    logic [ROM_AW-1:0] cls_rank;
    logic [ROM_AW-1:0] cls_base;
    logic              codes_ok;
    logic [ROM_AW-1:0] rom_addr;
    logic [DATA_W-1:0] rom_data;

    assign req_arr[0] = req_code0;
    assign req_arr[1] = req_code1;
    assign req_arr[2] = req_code2;
    assign req_arr[3] = req_code3;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_key
        assign raw_keys[g].code = req_arr[g];
        assign raw_keys[g].idx  = idx_t'(g);
    end

    clkmap_sorter u_sort (
        .keys_in  (raw_keys),
        .keys_out (sorted_keys)
    );

    clkmap_classifier u_cls (
        .sorted_keys (sorted_keys),
        .cat         (cls_cat),
        .slots       (cls_slots),
        .rank        (cls_rank),
        .entry_base  (cls_base),
        .codes_ok    (codes_ok)
    );

    clkmap_rom u_rom (
        .addr (rom_addr),
        .data (rom_data)
    );

    clkmap_writer u_wr (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .codes_ok    (codes_ok),
        .sorted_keys (sorted_keys),
        .slots       (cls_slots),
        .entry_base  (cls_base),
        .rom_data    (rom_data),
        .rom_addr    (rom_addr),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .done        (done),
        .err         (err)
    );

endmodule

// File: rtl/clkmap_checker.sv
module clkmap_checker
    import clkmap_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input key_vec_t          sorted_keys,
    input cat_e              cls_cat,
    input logic [ROM_AW-1:0] cls_rank,
    input logic              codes_ok,
    input logic              wr_valid,
    input logic [3:0]        wr_addr,
    input logic              done,
    input logic              err
);

    assert_sorted_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (sorted_keys[0] < sorted_keys[1]) && (sorted_keys[1] < sorted_keys[2]) &&
        (sorted_keys[2] < sorted_keys[3]));

    assert_rank_in_group_R10: assert property (@(posedge clk) disable iff (rst)
        codes_ok |-> (int'(cls_rank) < cat_entries(int'(cls_cat))));

    assert_first_write_common_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_valid) |-> (wr_addr == 4'd0));

    assert_addr_legal_R3: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_addr == 4'd0 || wr_addr == 4'd2 || wr_addr == 4'd5 ||
                      wr_addr == 4'd8 || wr_addr == 4'd11));

    assert_addr_order_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_addr != 4'd11) |=>
        (wr_valid && wr_addr == $past(wr_addr) + (($past(wr_addr) == 4'd0) ? 4'd2 : 4'd3)));

    assert_done_after_last_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (!wr_valid && $past(wr_valid) && $past(wr_addr) == 4'd11));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_err_silent_R8: assert property (@(posedge clk) disable iff (rst)
        err |-> (!wr_valid && !done));

endmodule

bind clkmap_top clkmap_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .sorted_keys (sorted_keys),
    .cls_cat     (cls_cat),
    .cls_rank    (cls_rank),
    .codes_ok    (codes_ok),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .done        (done),
    .err         (err)
);

// File: tb/clkmap_top_test.sv
module clkmap_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  rc0 = '0;
    logic [2:0]  rc1 = '0;
    logic [2:0]  rc2 = '0;
    logic [2:0]  rc3 = '0;
    logic        wr_valid;
    logic [3:0]  wr_addr;
    logic [31:0] wr_data;
    logic        done;
    logic        err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    clkmap_top uut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req_code0 (rc0),
        .req_code1 (rc1),
        .req_code2 (rc2),
        .req_code3 (rc3),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .done      (done),
        .err       (err)
    );

    function automatic int tb_gcd(int a, int b);
        int x = a;
        int y = b;
        int t;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    function automatic int tb_lcm4(int c0, int c1, int c2, int c3);
        int l = 1;
        int q [4];
        q[0] = c0 + 1; q[1] = c1 + 1; q[2] = c2 + 1; q[3] = c3 + 1;
        for (int i = 0; i < 4; i++) l = (l / tb_gcd(l, q[i])) * q[i];
        return l;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Issue one legal request; optionally inject a start with other codes mid-run.
    task automatic run_case(string req, int c0, int c1, int c2, int c3, bit inject);
        int l;
        int codes [4];
        codes[0] = c0; codes[1] = c1; codes[2] = c2; codes[3] = c3;
        l = tb_lcm4(c0, c1, c2, c3);
        rc0 = 3'(c0); rc1 = 3'(c1); rc2 = 3'(c2); rc3 = 3'(c3);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int s = 0; s < 5; s++) begin
            if (s > 0) @(negedge clk);
            if (inject && s == 1) begin
                start = 1'b1;
                rc0 = 3'((c0 + 1) % 6); rc1 = 3'((c1 + 2) % 6);
                rc2 = 3'((c2 + 3) % 6); rc3 = 3'((c3 + 4) % 6);
            end else if (inject && s == 2) begin
                start = 1'b0;
            end
            chk("R4", "wr_valid", int'(wr_valid), 1);
            if (s == 0) begin
                chk("R2", "common addr", int'(wr_addr), 0);
                chk(req, "common data", int'(wr_data), l);
            end else begin
                chk("R3", "output addr", int'(wr_addr), 2 + 3 * (s - 1));
                chk(req, "output data", int'(wr_data), l / (codes[s-1] + 1));
            end
        end
        @(negedge clk);
        chk("R5", "done", int'(done), 1);
        chk("R5", "valid at done", int'(wr_valid), 0);
        @(negedge clk);
        chk("R5", "done width", int'(done), 0);
        chk(inject ? "R6" : "R4", "no extra write", int'(wr_valid), 0);
        @(negedge clk);
        chk(inject ? "R6" : "R4", "stays idle", int'(wr_valid), 0);
    endtask

    task automatic run_bad(int c0, int c1, int c2, int c3);
        rc0 = 3'(c0); rc1 = 3'(c1); rc2 = 3'(c2); rc3 = 3'(c3);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8", "err pulse", int'(err), 1);
        chk("R8", "no write", int'(wr_valid), 0);
        for (int s = 0; s < 6; s++) begin
            @(negedge clk);
            chk("R8", "quiet valid", int'(wr_valid), 0);
            chk("R8", "quiet done", int'(done), 0);
            if (s == 0) chk("R8", "err width", int'(err), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int c [4];
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", int'(wr_valid), 0);
        chk("R1", "done in reset", int'(done), 0);
        chk("R1", "err in reset", int'(err), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "valid after reset", int'(wr_valid), 0);
        chk("R1", "done after reset", int'(done), 0);
        chk("R1", "err after reset", int'(err), 0);

        run_case("R7", 2, 3, 5, 1, 1'b0);
        run_case("R7", 5, 1, 2, 3, 1'b0);
        run_case("R7", 0, 4, 4, 2, 1'b0);
        run_case("R7", 3, 0, 3, 0, 1'b0);
        run_case("R7", 1, 5, 1, 1, 1'b0);
        run_case("R7", 5, 5, 5, 5, 1'b0);
        run_case("R7", 0, 0, 0, 0, 1'b0);
        run_case("R7", 3, 4, 5, 0, 1'b0);
        run_case("R6", 1, 2, 3, 4, 1'b1);
        run_bad(6, 0, 1, 2);
        run_bad(0, 0, 0, 7);

        for (int n = 0; n < 120; n++) begin
            for (int i = 0; i < 4; i++) c[i] = int'($urandom % 6);
            if (($urandom % 8) == 0) begin
                c[$urandom % 4] = 6 + int'($urandom % 2);
                run_bad(c[0], c[1], c[2], c[3]);
            end else begin
                run_case("R3", c[0], c[1], c[2], c[3], 1'b0);
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule